// File: doc/BRIEF.md
# DMA Bus Error Retry Controller

This block sits next to a DMA engine and decides what to do when a bus cycle ends in a bus error. It holds a byte-wide retry budget that the host can read and write. When an error arrives and the budget is non-zero, the block asks the DMA engine to re-issue the same transfer, with the same address, data and size, and takes one from the budget. When an error arrives and the budget is zero, the block raises an interrupt. It also suspends DMA to the failing buffer and records whether that transfer was a receive or a transmit.

The suspension and the interrupt both stay in force until the host pulses the acknowledge input. While the block is suspended, the host can load a fresh budget. The DMA engine reports the end of each bus cycle on `xfer_done`, and `bus_err` qualifies that ending. There is no streaming data path, so every pin is a plain level or a single-cycle pulse. No input has back-pressure. The retry request is a one-cycle strobe that the DMA engine must take when it is issued.

Top module: `berr_retry_ctrl`

## Requirements
- R1: After reset the retry budget reads 0x00 on `host_rdata`, and `retry_req`, `suspend` and `irq` are all low.
- R2: A cycle with `host_wr` high loads `host_wdata` into the budget, which reads back on `host_rdata` from the next cycle.
- R3: An error ending (`xfer_done` and `bus_err` both high) while the budget is non-zero and the block is not suspended raises `retry_req` for exactly one cycle, in the next cycle. In that same cycle the budget reads one less.
- R4: An error ending while the budget is zero and the block is not suspended sets `irq` and `suspend` in the next cycle. It leaves the budget at zero and issues no retry.
- R5: `irq` and `suspend` stay high until a cycle with `irq_ack` high. After that cycle both are low.
- R6: While `suspend` is high, error endings are ignored: no retry is issued, and the budget and the cause flag do not change. Host writes still load the budget.
- R7: When a host write and an error-driven decrement fall in the same cycle, the budget takes the written value. The retry is still issued.
- R8: `bus_err` without `xfer_done`, and `xfer_done` without `bus_err`, have no effect. An error ending in the cycle in which `retry_req` is high is also ignored, since the retried cycle cannot have ended yet.
- R9: On an interrupting error, `irq_cause_rx` captures `xfer_rx` (1 = receive, 0 = transmit). It holds that value while `irq` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe for the retry budget |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Current retry budget |
| xfer_done | input | 1 | A DMA bus cycle ends this clock |
| bus_err | input | 1 | The ending bus cycle failed |
| xfer_rx | input | 1 | Direction of the ending cycle, 1 = receive |
| retry_req | output | 1 | One-cycle request to re-issue the same transfer |
| suspend | output | 1 | DMA to the failing buffer is held off |
| irq | output | 1 | Bus error interrupt |
| irq_cause_rx | output | 1 | Interrupt cause, 1 = receive, 0 = transmit |
| irq_ack | input | 1 | Host acknowledge pulse |

## Verification
The hardest situations to reach are the ones where two events meet in one clock. The first is an error ending while the block is already suspended. The second is an error ending on the same edge as a host write. The third is a second error ending in the very cycle after a retry request. Each test drives the inputs on the falling edge and lines up the strobes in one cycle on purpose. It first walks the budget down to zero so that the block reaches suspension, then fires further error endings there. Each outcome is read back at the ports: `host_rdata`, `retry_req` and `irq_cause_rx`.

// File: rtl/berr_retry_pkg.sv
package berr_retry_pkg;
  localparam int unsigned BUDGET_W = 8;

  typedef enum logic {
    CAUSE_TX = 1'b0,
    CAUSE_RX = 1'b1
  } berr_cause_e;
endpackage

// File: rtl/berr_budget.sv
module berr_budget #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic         cnt_zero
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (wr_en) cnt <= wr_data;      // host has priority
    else if (dec)   cnt <= cnt - ONE;
  end

  assign cnt_zero = (cnt == '0);

  // R7
  host_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cnt == $past(wr_data));

  // R3
  dec_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !wr_en) |=> cnt == $past(cnt) - ONE);

  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> !cnt_zero);
endmodule

// File: rtl/berr_retry_pulse.sv
module berr_retry_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic retry_req
);
  always_ff @(posedge clk) begin
    if (!rst_n) retry_req <= 1'b0;
    else        retry_req <= fire;
  end

  // R3
  one_cycle_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retry_req |=> !retry_req);
endmodule

// File: rtl/berr_irq_latch.sv
module berr_irq_latch
  import berr_retry_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        raise,
  input  logic        rx_dir,
  input  logic        ack,
  output logic        irq,
  output logic        suspend,
  output berr_cause_e cause
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq     <= 1'b0;
      suspend <= 1'b0;
      cause   <= CAUSE_TX;
    end else if (raise) begin
      irq     <= 1'b1;
      suspend <= 1'b1;
      cause   <= rx_dir ? CAUSE_RX : CAUSE_TX;
    end else if (ack) begin
      irq     <= 1'b0;
      suspend <= 1'b0;
    end
  end

  // R5
  irq_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack) |=> irq && suspend);

  // R5
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (suspend && ack) |=> !irq && !suspend);

  // R9
  cause_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack) |=> $stable(cause));
endmodule

// File: rtl/berr_retry_ctrl.sv
module berr_retry_ctrl
  import berr_retry_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_wr,
  input  logic [BUDGET_W-1:0] host_wdata,
  output logic [BUDGET_W-1:0] host_rdata,
  input  logic                xfer_done,
  input  logic                bus_err,
  input  logic                xfer_rx,
  output logic                retry_req,
  output logic                suspend,
  output logic                irq,
  output logic                irq_cause_rx,
  input  logic                irq_ack
);
  logic                err_end;
  logic                do_retry;
  logic                do_irq;
  logic                cnt_zero;
  logic [BUDGET_W-1:0] cnt;
  berr_cause_e         cause;

  // an error ending counts only when the engine is live and no retry is pending
  assign err_end  = xfer_done && bus_err && !suspend && !retry_req;
  assign do_retry = err_end && !cnt_zero;
  assign do_irq   = err_end &&  cnt_zero;

  berr_budget #(.W(BUDGET_W)) u_budget (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (host_wr),
    .wr_data  (host_wdata),
    .dec      (do_retry),
    .cnt      (cnt),
    .cnt_zero (cnt_zero)
  );

  berr_retry_pulse u_pulse (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (do_retry),
    .retry_req (retry_req)
  );

  berr_irq_latch u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .raise   (do_irq),
    .rx_dir  (xfer_rx),
    .ack     (irq_ack),
    .irq     (irq),
    .suspend (suspend),
    .cause   (cause)
  );

  assign host_rdata   = cnt;
  assign irq_cause_rx = (cause == CAUSE_RX);

  // R6
  no_retry_when_suspended_chk: assert property (@(posedge clk) disable iff (!rst_n)
    suspend |=> !retry_req);

  // R4
  retry_xor_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(retry_req && $rose(irq)));
endmodule

// File: tb/test_berr_retry_ctrl.sv
`timescale 1ns/1ps
module test_berr_retry_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       xfer_done = 1'b0;
  logic       bus_err = 1'b0;
  logic       xfer_rx = 1'b0;
  logic       retry_req, suspend, irq, irq_cause_rx;
  logic       irq_ack = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  berr_retry_ctrl i_berr_retry_ctrl (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .xfer_done(xfer_done), .bus_err(bus_err),
    .xfer_rx(xfer_rx), .retry_req(retry_req), .suspend(suspend), .irq(irq),
    .irq_cause_rx(irq_cause_rx), .irq_ack(irq_ack)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic host_write(input logic [7:0] v);
    host_wr = 1'b1; host_wdata = v;
    step();
    host_wr = 1'b0;
  endtask

  task automatic err_end(input logic rx);
    xfer_done = 1'b1; bus_err = 1'b1; xfer_rx = rx;
    step();
    xfer_done = 1'b0; bus_err = 1'b0;
  endtask

  task automatic ack;
    irq_ack = 1'b1;
    step();
    irq_ack = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 budget", host_rdata, 8'h00);
    chk("R1 retry", {7'b0, retry_req}, 8'h0);
    chk("R1 suspend", {7'b0, suspend}, 8'h0);
    chk("R1 irq", {7'b0, irq}, 8'h0);
  endtask

  task automatic t_write_read;
    host_write(8'hA5);
    chk("R2 readback", host_rdata, 8'hA5);
    host_write(8'h00);
    chk("R2 readback zero", host_rdata, 8'h00);
  endtask

  task automatic t_countdown;
    host_write(8'h02);
    err_end(1'b0);
    chk("R3 retry 1", {7'b0, retry_req}, 8'h1);
    chk("R3 dec to 1", host_rdata, 8'h01);
    step();
    chk("R3 retry one cycle", {7'b0, retry_req}, 8'h0);
    err_end(1'b0);
    chk("R3 retry 2", {7'b0, retry_req}, 8'h1);
    chk("R3 dec to 0", host_rdata, 8'h00);
    step();
    err_end(1'b0);
    chk("R4 irq", {7'b0, irq}, 8'h1);
    chk("R4 suspend", {7'b0, suspend}, 8'h1);
    chk("R4 no retry", {7'b0, retry_req}, 8'h0);
    chk("R4 budget stays", host_rdata, 8'h00);
    chk("R9 cause tx", {7'b0, irq_cause_rx}, 8'h0);
    ack();
    chk("R5 irq cleared", {7'b0, irq}, 8'h0);
  endtask

  task automatic t_hold_ack;
    err_end(1'b1);
    chk("R9 cause rx", {7'b0, irq_cause_rx}, 8'h1);
    for (int i = 0; i < 5; i++) step();
    chk("R5 irq held", {7'b0, irq}, 8'h1);
    chk("R5 suspend held", {7'b0, suspend}, 8'h1);
    chk("R9 cause held", {7'b0, irq_cause_rx}, 8'h1);
    ack();
    chk("R5 ack irq", {7'b0, irq}, 8'h0);
    chk("R5 ack suspend", {7'b0, suspend}, 8'h0);
  endtask

  task automatic t_suspended_ignore;
    err_end(1'b1);
    host_write(8'h03);
    chk("R6 write while suspended", host_rdata, 8'h03);
    err_end(1'b0);
    chk("R6 no retry", {7'b0, retry_req}, 8'h0);
    chk("R6 budget kept", host_rdata, 8'h03);
    chk("R6 cause kept", {7'b0, irq_cause_rx}, 8'h1);
    ack();
    err_end(1'b0);
    chk("R6 retry after ack", {7'b0, retry_req}, 8'h1);
    chk("R6 dec after ack", host_rdata, 8'h02);
    step();
  endtask

  task automatic t_collide;
    host_write(8'h05);
    host_wr = 1'b1; host_wdata = 8'h40;
    xfer_done = 1'b1; bus_err = 1'b1; xfer_rx = 1'b0;
    step();
    host_wr = 1'b0; xfer_done = 1'b0; bus_err = 1'b0;
    chk("R7 write wins", host_rdata, 8'h40);
    chk("R7 retry issued", {7'b0, retry_req}, 8'h1);
    step();
  endtask

  task automatic t_qualify;
    host_write(8'h04);
    bus_err = 1'b1;
    step();
    bus_err = 1'b0;
    chk("R8 err alone retry", {7'b0, retry_req}, 8'h0);
    chk("R8 err alone budget", host_rdata, 8'h04);
    xfer_done = 1'b1;
    step();
    xfer_done = 1'b0;
    chk("R8 done alone retry", {7'b0, retry_req}, 8'h0);
    chk("R8 done alone budget", host_rdata, 8'h04);
    xfer_done = 1'b1; bus_err = 1'b1;
    step();
    chk("R8 first error retry", {7'b0, retry_req}, 8'h1);
    step();
    xfer_done = 1'b0; bus_err = 1'b0;
    chk("R8 second error no retry", {7'b0, retry_req}, 8'h0);
    chk("R8 single decrement", host_rdata, 8'h03);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_write_read();
    t_countdown();
    t_hold_ack();
    t_suspended_ignore();
    t_collide();
    t_qualify();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule